// File: doc/BRIEF.md
# Palette DAC Host Register File

This block is the host-facing register file of a video palette DAC. A host CPU reaches it through one byte-wide port with a four-bit register select and separate read and write strobes. It holds the DAC control registers, the cursor position, and the pointer used to load the external cursor RAM. It drives decoded control fields to the cursor, interlace, DAC-width and sync-on-green logic elsewhere in the chip.

One control register is not directly addressable. It sits behind the status port. When an indirect-enable bit in control register 0 is set, the status port stops returning status. It then accesses an extended register whose index is the current value of the write-address register. Index 0 selects the extended register. That register's two low bits also form the top of the 10-bit cursor RAM pointer. Each byte written to the cursor data port goes out on a RAM write strobe at the current pointer, and the pointer then advances by one. The carry from the low byte runs into the extended register.

Top module: `dac_host_regs`

## Requirements
- R1: While `rst_ni` is low, every control register, the cursor pointer and both position registers are zero. So after reset `cursor_en_o`, `dac_8bit_o`, `sync_on_green_o` and `cursor_64_o` are low, indirect access is off and `cur_addr_o` is 0.
- R2: The register select decodes as follows:
  - 0: write address
  - 1: control 0
  - 2: control 1
  - 3: control 2
  - 4: status/indirect
  - 5: cursor data
  - 6: X low
  - 7: X high
  - 8: Y low
  - 9: Y high

  Controls 0 to 2 read back the last byte written.
- R3: Control 0 bit 1 drives `dac_8bit_o` (1 = 8-bit data, 0 = 6-bit). Control 0 bit 3 drives `sync_on_green_o`. Both change only on a control 0 write.
- R4: Control 2 bits 1:0 drive `cursor_mode_o` (00 = cursor off, 11 = two-colour with transparency). `cursor_en_o` is high whenever the mode is non-zero. Control 2 bit 3 drives `cursor_interlace_o`.
- R5: With control 0 bit 7 clear, reading select 4 returns `status_i`. Writing select 4 changes no register.
- R6: With control 0 bit 7 set and the write-address register at 0, select 4 reads and writes the extended register. Its bit 2 drives `cursor_64_o`, and its bits 1:0 are bits 9:8 of the cursor pointer.
- R7: With control 0 bit 7 set and a non-zero write-address register, reading select 4 returns 0. Writing select 4 changes nothing.
- R8: A write to select 5 raises `cur_we_o` in the same cycle, with `cur_addr_o` equal to {extended[1:0], write address} and `cur_wdata_o` equal to the written byte. From the next cycle the pointer is one higher. A read of select 5 returns 0 and leaves the pointer alone.
- R9: The pointer increment carries from the write-address byte into extended bits 1:0 and wraps from 1023 to 0. 1024 data writes from 0 visit every address once and end at 0.
- R10: X and Y low bytes read back as written. The high registers keep four bits and read back with bits 7:4 zero. `cursor_x_o` and `cursor_y_o` are {high nibble, low byte}, and they change only on position writes.
- R11: `rdata_o` is 0 when `rd_i` is low. Selects 10 to 15 read as 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register select |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Write strobe, one register per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| status_i | input | 8 | Sense/status byte from the analog side |
| cur_we_o | output | 1 | Cursor RAM write strobe |
| cur_addr_o | output | 10 | Cursor RAM pointer |
| cur_wdata_o | output | 8 | Cursor RAM write data |
| dac_8bit_o | output | 1 | 8-bit DAC data select |
| sync_on_green_o | output | 1 | Sync on green enable |
| cursor_mode_o | output | 2 | Cursor mode field |
| cursor_en_o | output | 1 | Cursor enabled (mode non-zero) |
| cursor_interlace_o | output | 1 | Interlaced cursor handling |
| cursor_64_o | output | 1 | 64x64 cursor size |
| cursor_x_o | output | 12 | Cursor X position |
| cursor_y_o | output | 12 | Cursor Y position |

## Verification
Read data and the cursor RAM strobe, address and data are combinational. The bench samples them one time unit after driving the inputs at the falling edge, within that same cycle. Register contents, decoded fields and the advanced pointer appear after the next rising edge. The bench checks them one time unit after that edge, or through a read in a following cycle. The 1024-write pointer sweep checks each write's address in its own cycle, which covers both the carry and the wrap.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int CUR_EXT_W = 2;
  localparam int N_REG     = 10;
  localparam int N_AXIS    = 2;
  localparam int POS_BASE  = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_WADDR = 4'd0,
    SEL_CTL0  = 4'd1,
    SEL_CTL1  = 4'd2,
    SEL_CTL2  = 4'd3,
    SEL_STAT  = 4'd4,
    SEL_CDATA = 4'd5,
    SEL_XLO   = 4'd6,
    SEL_XHI   = 4'd7,
    SEL_YLO   = 4'd8,
    SEL_YHI   = 4'd9
  } reg_sel_e;

  // control field positions
  localparam int CTL0_DAC8_BIT = 1;
  localparam int CTL0_SOG_BIT  = 3;
  localparam int CTL0_IND_BIT  = 7;
  localparam int CTL2_ILACE_BIT = 3;
  localparam int EXT_SIZE_BIT   = 2;
endpackage

// File: rtl/dac_host_decode.sv
module dac_host_decode
  import dac_host_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              ind_en_i,
  input  logic              idx_zero_i,
  output logic              waddr_we_o,
  output logic              cdata_we_o,
  output logic [2:0]        ctl_we_o,
  output logic              ext_we_o,
  output logic [2*N_AXIS-1:0] pos_we_o
);
  logic [N_REG-1:0] hit;

  for (genvar k = 0; k < N_REG; k++) begin : g_hit
    assign hit[k] = wr_i && (addr_i == ADDR_W'(k));
  end

  for (genvar c = 0; c < 3; c++) begin : g_ctl
    assign ctl_we_o[c] = hit[int'(SEL_CTL0) + c];
  end

  for (genvar p = 0; p < 2*N_AXIS; p++) begin : g_pos
    assign pos_we_o[p] = hit[POS_BASE + p];
  end

  assign waddr_we_o = hit[SEL_WADDR];
  assign cdata_we_o = hit[SEL_CDATA];
  // status port is writable only through the indirect window at index 0
  assign ext_we_o   = hit[SEL_STAT] && ind_en_i && idx_zero_i;
endmodule

// File: rtl/dac_cursor_ptr.sv
module dac_cursor_ptr #(
  parameter int LO_W  = 8,
  parameter int EXT_W = 2,
  localparam int PTR_W = LO_W + EXT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_we_i,
  input  logic [LO_W-1:0]  lo_d_i,
  input  logic             ext_we_i,
  input  logic [EXT_W-1:0] ext_d_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (lo_we_i)       ptr_d[LO_W-1:0]     = lo_d_i;
    else if (ext_we_i) ptr_d[PTR_W-1:LO_W] = ext_d_i;
    else if (inc_i)    ptr_d               = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_host_pkg::*;
#(
  parameter int POS_W = 12,
  localparam int HI_W  = POS_W - DATA_W,
  localparam int EXT_HI_W = DATA_W - CUR_EXT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [2:0]          ctl_we_i,
  input  logic                ext_we_i,
  input  logic [2*N_AXIS-1:0] pos_we_i,
  output logic [DATA_W-1:0]   ctl_o [3],
  output logic [EXT_HI_W-1:0] ext_hi_o,
  output logic [DATA_W-1:0]   pos_lo_o [N_AXIS],
  output logic [HI_W-1:0]     pos_hi_o [N_AXIS]
);
  for (genvar c = 0; c < 3; c++) begin : g_ctl
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= '0;
      else if (ctl_we_i[c]) q <= wdata_i;
    end
    assign ctl_o[c] = q;
  end

  logic [EXT_HI_W-1:0] ext_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ext_hi_q <= '0;
    else if (ext_we_i) ext_hi_q <= wdata_i[DATA_W-1:CUR_EXT_W];
  end
  assign ext_hi_o = ext_hi_q;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (pos_we_i[2*a])   lo_q <= wdata_i;
        if (pos_we_i[2*a+1]) hi_q <= wdata_i[HI_W-1:0];
      end
    end
    assign pos_lo_o[a] = lo_q;
    assign pos_hi_o[a] = hi_q;
  end
endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs
  import dac_host_pkg::*;
#(
  parameter int POS_W = 12,
  localparam int CUR_AW = DATA_W + CUR_EXT_W,
  localparam int HI_W   = POS_W - DATA_W,
  localparam int EXT_HI_W = DATA_W - CUR_EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] status_i,
  output logic              cur_we_o,
  output logic [CUR_AW-1:0] cur_addr_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output logic              dac_8bit_o,
  output logic              sync_on_green_o,
  output logic [1:0]        cursor_mode_o,
  output logic              cursor_en_o,
  output logic              cursor_interlace_o,
  output logic              cursor_64_o,
  output logic [POS_W-1:0]  cursor_x_o,
  output logic [POS_W-1:0]  cursor_y_o
);
  logic                waddr_we, cdata_we, ext_we;
  logic [2:0]          ctl_we;
  logic [2*N_AXIS-1:0] pos_we;
  logic [CUR_AW-1:0]   ptr;
  logic [DATA_W-1:0]   ctl [3];
  logic [EXT_HI_W-1:0] ext_hi;
  logic [DATA_W-1:0]   pos_lo [N_AXIS];
  logic [HI_W-1:0]     pos_hi [N_AXIS];
  logic                ind_en;
  logic                idx_zero;
  logic [DATA_W-1:0]   ext_rd;
  logic [DATA_W-1:0]   rd_mux;

  assign ind_en   = ctl[0][CTL0_IND_BIT];
  assign idx_zero = (ptr[DATA_W-1:0] == '0);

  dac_host_decode u_dec (
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .ind_en_i   (ind_en),
    .idx_zero_i (idx_zero),
    .waddr_we_o (waddr_we),
    .cdata_we_o (cdata_we),
    .ctl_we_o   (ctl_we),
    .ext_we_o   (ext_we),
    .pos_we_o   (pos_we)
  );

  dac_cursor_ptr #(.LO_W(DATA_W), .EXT_W(CUR_EXT_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lo_we_i  (waddr_we),
    .lo_d_i   (wdata_i),
    .ext_we_i (ext_we),
    .ext_d_i  (wdata_i[CUR_EXT_W-1:0]),
    .inc_i    (cdata_we),
    .ptr_o    (ptr)
  );

  dac_ctrl_regs #(.POS_W(POS_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wdata_i),
    .ctl_we_i (ctl_we),
    .ext_we_i (ext_we),
    .pos_we_i (pos_we),
    .ctl_o    (ctl),
    .ext_hi_o (ext_hi),
    .pos_lo_o (pos_lo),
    .pos_hi_o (pos_hi)
  );

  assign ext_rd = {ext_hi, ptr[CUR_AW-1:DATA_W]};

  always_comb begin
    unique case (addr_i)
      SEL_WADDR: rd_mux = ptr[DATA_W-1:0];
      SEL_CTL0:  rd_mux = ctl[0];
      SEL_CTL1:  rd_mux = ctl[1];
      SEL_CTL2:  rd_mux = ctl[2];
      SEL_STAT:  rd_mux = !ind_en ? status_i : (idx_zero ? ext_rd : '0);
      SEL_XLO:   rd_mux = pos_lo[0];
      SEL_XHI:   rd_mux = DATA_W'(pos_hi[0]);
      SEL_YLO:   rd_mux = pos_lo[1];
      SEL_YHI:   rd_mux = DATA_W'(pos_hi[1]);
      default:   rd_mux = '0;
    endcase
  end

  assign rdata_o     = rd_i ? rd_mux : '0;
  assign cur_we_o    = cdata_we;
  assign cur_addr_o  = ptr;
  assign cur_wdata_o = wdata_i;

  assign dac_8bit_o         = ctl[0][CTL0_DAC8_BIT];
  assign sync_on_green_o    = ctl[0][CTL0_SOG_BIT];
  assign cursor_mode_o      = ctl[2][1:0];
  assign cursor_en_o        = |ctl[2][1:0];
  assign cursor_interlace_o = ctl[2][CTL2_ILACE_BIT];
  assign cursor_64_o        = ext_hi[EXT_SIZE_BIT-CUR_EXT_W];
  assign cursor_x_o         = {pos_hi[0], pos_lo[0]};
  assign cursor_y_o         = {pos_hi[1], pos_lo[1]};
endmodule

// File: rtl/dac_host_regs_chk.sv
module dac_host_regs_chk
  import dac_host_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] status_i,
  input logic              ind_en_i,
  input logic              cur_we_o,
  input logic [9:0]        cur_addr_o,
  input logic              dac_8bit_o,
  input logic              sync_on_green_o,
  input logic [1:0]        cursor_mode_o,
  input logic              cursor_interlace_o,
  input logic              cursor_64_o,
  input logic [11:0]       cursor_x_o,
  input logic [11:0]       cursor_y_o
);
  logic stat_wr, pos_wr;
  assign stat_wr = wr_i && addr_i == SEL_STAT;
  assign pos_wr  = wr_i && addr_i >= SEL_XLO && addr_i <= SEL_YHI;

  assert_ctl0_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == SEL_CTL0) |=> $stable(dac_8bit_o) && $stable(sync_on_green_o));

  assert_ctl2_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == SEL_CTL2) |=> $stable(cursor_mode_o) && $stable(cursor_interlace_o));

  assert_status_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == SEL_STAT && !ind_en_i) |-> rdata_o == status_i);

  assert_status_wr_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !ind_en_i) |=> $stable(cur_addr_o) && $stable(cursor_64_o));

  assert_bad_index_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && ind_en_i && cur_addr_o[7:0] != 8'h00) |=> $stable(cur_addr_o) && $stable(cursor_64_o));

  assert_ptr_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_we_o |=> cur_addr_o == 10'($past(cur_addr_o) + 10'd1));

  assert_ptr_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_we_o && cur_addr_o == 10'h3FF) |=> cur_addr_o == 10'h000);

  assert_pos_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pos_wr |=> $stable(cursor_x_o) && $stable(cursor_y_o));

  assert_idle_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
endmodule

bind dac_host_regs dac_host_regs_chk u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .addr_i             (addr_i),
  .wr_i               (wr_i),
  .rd_i               (rd_i),
  .rdata_o            (rdata_o),
  .status_i           (status_i),
  .ind_en_i           (ind_en),
  .cur_we_o           (cur_we_o),
  .cur_addr_o         (cur_addr_o),
  .dac_8bit_o         (dac_8bit_o),
  .sync_on_green_o    (sync_on_green_o),
  .cursor_mode_o      (cursor_mode_o),
  .cursor_interlace_o (cursor_interlace_o),
  .cursor_64_o        (cursor_64_o),
  .cursor_x_o         (cursor_x_o),
  .cursor_y_o         (cursor_y_o)
);

// File: tb/tb_dac_host_regs.sv
module tb_dac_host_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] status_i = 8'hA5;
  logic       cur_we_o;
  logic [9:0] cur_addr_o;
  logic [7:0] cur_wdata_o;
  logic       dac_8bit_o, sync_on_green_o, cursor_en_o, cursor_interlace_o, cursor_64_o;
  logic [1:0] cursor_mode_o;
  logic [11:0] cursor_x_o, cursor_y_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dac_host_regs dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    // R1 reset state, sampled while reset is held
    chk("R1 cur_addr", cur_addr_o, 0);
    chk("R1 cursor_en", cursor_en_o, 0);
    chk("R1 dac_8bit", dac_8bit_o, 0);
    chk("R1 cursor_64", cursor_64_o, 0);
    chk("R1 pos", {cursor_x_o, cursor_y_o}, 0);
    chk("R11 idle rdata", rdata_o, 0);
    rst_ni = 1'b1;
    rd(4'd1, r); chk("R1 ctl0", r, 0);
    rd(4'd3, r); chk("R1 ctl2", r, 0);
    rd(4'd4, r); chk("R5 status after reset", r, 8'hA5);

    // R2 control 1 sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd2, 8'(v)); rd(4'd2, r); chk("R2 ctl1 readback", r, v);
    end
    // R3 control 0 sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd1, 8'(v));
      chk("R3 dac_8bit", dac_8bit_o, (v >> 1) & 1);
      chk("R3 sync_on_green", sync_on_green_o, (v >> 3) & 1);
      rd(4'd1, r); chk("R2 ctl0 readback", r, v);
    end
    wr(4'd1, 8'h00);
    // R4 control 2 sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd3, 8'(v));
      chk("R4 cursor_mode", cursor_mode_o, v & 3);
      chk("R4 cursor_en", cursor_en_o, ((v & 3) != 0) ? 1 : 0);
      chk("R4 interlace", cursor_interlace_o, (v >> 3) & 1);
      rd(4'd3, r); chk("R2 ctl2 readback", r, v);
    end

    // R5 status port, writes ignored when indirect is off
    status_i = 8'h3C;
    rd(4'd4, r); chk("R5 status read", r, 8'h3C);
    wr(4'd0, 8'h00);
    wr(4'd4, 8'hFF);
    chk("R5 write ignored cur_addr", cur_addr_o, 0);
    chk("R5 write ignored size", cursor_64_o, 0);
    wr(4'd1, 8'h80);
    rd(4'd4, r); chk("R5 ext untouched", r, 8'h00);

    // R6 indirect index 0
    wr(4'd4, 8'h04);
    chk("R6 cursor_64", cursor_64_o, 1);
    rd(4'd4, r); chk("R6 ext readback", r, 8'h04);
    wr(4'd4, 8'hF9);
    chk("R6 ext bits as pointer", cur_addr_o, 10'h100);
    rd(4'd4, r); chk("R6 ext readback 2", r, 8'hF9);
    chk("R6 cursor_64 cleared", cursor_64_o, 0);

    // R7 non-zero index
    wr(4'd0, 8'h05);
    chk("R7 pointer", cur_addr_o, 10'h105);
    rd(4'd4, r); chk("R7 read zero", r, 8'h00);
    wr(4'd4, 8'h06);
    chk("R7 write ignored", {cursor_64_o, cur_addr_o}, {1'b0, 10'h105});
    wr(4'd0, 8'h00);
    rd(4'd4, r); chk("R7 ext kept", r, 8'hF9);

    // R8/R9 full cursor RAM sweep from 0
    wr(4'd4, 8'h04);
    chk("R9 start", cur_addr_o, 0);
    rd(4'd5, r); chk("R8 data read zero", r, 0);
    chk("R8 data read no move", cur_addr_o, 0);
    chk("R8 no strobe idle", cur_we_o, 0);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk_i);
      addr_i = 4'd5; wdata_i = 8'(i ^ 8'h5A); wr_i = 1'b1;
      #1;
      chk("R8 strobe", cur_we_o, 1);
      chk("R9 address", cur_addr_o, i);
      chk("R8 data", cur_wdata_o, (i ^ 8'h5A) & 8'hFF);
      @(posedge clk_i); #1;
      wr_i = 1'b0;
    end
    chk("R9 wrap", cur_addr_o, 0);
    rd(4'd4, r); chk("R9 carry wrapped ext", r, 8'h04);
    rd(4'd0, r); chk("R9 waddr wrapped", r, 8'h00);

    // R10 position sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd6, 8'(v)); wr(4'd7, 8'(v ^ 8'hC3));
      wr(4'd8, 8'(~v)); wr(4'd9, 8'(v + 7));
      chk("R10 x", cursor_x_o, {4'((v ^ 8'hC3) & 15), 8'(v)});
      chk("R10 y", cursor_y_o, {4'((v + 7) & 15), 8'(~v)});
      rd(4'd7, r); chk("R10 xhi readback", r, (v ^ 8'hC3) & 15);
      rd(4'd8, r); chk("R10 ylo readback", r, (~v) & 8'hFF);
    end

    // R11 unmapped selects
    wr(4'd2, 8'h6E);
    for (int a = 10; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), r); chk("R11 unmapped read", r, 0);
    end
    rd(4'd2, r); chk("R11 ctl1 intact", r, 8'h6E);
    chk("R11 pos intact", cursor_x_o, {4'((255 ^ 8'hC3) & 15), 8'hFF});
    @(negedge clk_i); #1;
    chk("R11 idle rdata", rdata_o, 0);

    done = 1'b1;
    summary();
  end
endmodule